// File: doc/BRIEF.md
# Masked Port Change Interrupt

This block watches a group of seven general-purpose port levels for any change against a stored reference copy and raises a sticky interrupt when one is seen. Software chooses which ports take part through a seven-bit enable register. A configuration write with the arm flag set captures the reference copy and starts watching. The interrupt is cleared only by touching the enable register, and a read counts as well as a write.

Detection is one-shot. Once an interrupt has been taken and cleared, watching stays off until software arms again, even though its own arm flag is still set. The port levels come from the pad side and are asynchronous, so each one passes through a two-flop synchronizer before the compare. Any level that is held for at least one clock period is therefore caught, however short it is otherwise. The compare does not depend on whether a monitored pin is driven as an output or read as an input.

Top module: `port_change_watch`

## Requirements
- R1: During and after reset, `irq_o` is 0, the enable register reads 0x00 and detection is disarmed.
- R2: A write of the enable register stores `mask_wdata_i`. Bit n set enables monitoring of `port_lvl_i[n]`. `mask_rdata_o` presents the stored bits in [6:0], and bit 7 always reads 0.
- R3: A configuration write with the arm flag set does three things: it copies the synchronized port levels into the reference, arms detection and forces `irq_o` low. This happens whether or not detection was already armed.
- R4: A configuration write with the arm flag clear disarms detection, and later port changes raise no interrupt.
- R5: While armed, an enabled port whose level differs from its reference bit for at least one clock period drives `irq_o` high within four clock edges.
- R6: Once high, `irq_o` stays high when the ports return to the reference levels or keep changing.
- R7: Any access to the enable register, read or write, clears `irq_o` and disarms detection until the next arming write.
- R8: A change on a port whose enable bit is 0 never raises `irq_o`.
- R9: Several events can land in the same clock. An arming write beats an enable-register access: the block ends up armed with `irq_o` low. An enable-register access beats a new change: `irq_o` ends up low. An arming write beats a new change: the new levels become the reference and `irq_o` ends up low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_lvl_i | input | 7 | Raw port levels; bit n is the nth watched port |
| cfg_wr_i | input | 1 | One-cycle configuration write strobe |
| cfg_arm_i | input | 1 | Arm flag carried by the configuration write |
| mask_acc_i | input | 1 | One-cycle enable-register access strobe (read or write) |
| mask_wr_i | input | 1 | With `mask_acc_i`: 1 = write, 0 = read |
| mask_wdata_i | input | 7 | Enable bits to store |
| mask_rdata_o | output | 8 | Enable register read value, bit 7 zero |
| irq_o | output | 1 | Sticky change interrupt, active high |

## Verification
The events that can fall in the same cycle are a detected change and an arming write, a detected change and an enable-register access, and an arming write together with an enable-register access. To provoke a collision with a change, the bench moves a port and then counts two synchronizer edges, so that the strobe is asserted in exactly the cycle the compare first sees the new level. After each collision the bench judges `irq_o`. It then moves a port again, which shows whether detection was left armed or disarmed.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  localparam int PCW_MAXW = 32;

  // High when any enabled bit of the current level differs from the reference.
  function automatic logic pcw_any_diff(input logic [PCW_MAXW-1:0] lvl,
                                        input logic [PCW_MAXW-1:0] ref_bits,
                                        input logic [PCW_MAXW-1:0] en);
    return |((lvl ^ ref_bits) & en);
  endfunction

  // Read value: enable bits in the low part, upper bits zero.
  function automatic logic [PCW_MAXW-1:0] pcw_read_val(input logic [PCW_MAXW-1:0] en);
    return en;
  endfunction
endpackage

// File: rtl/pcw_sync2.sv
module pcw_sync2 #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[b];
        s2 <= s1;
      end
    end
    assign q_o[b] = s2;
  end
endmodule

// File: rtl/pcw_mask_reg.sv
module pcw_mask_reg
  import pcw_pkg::*;
#(
  parameter int NP = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_i,
  input  logic          wr_i,
  input  logic [NP-1:0] wdata_i,
  output logic [NP-1:0] en_o,
  output logic [NP:0]   rdata_o
);
  localparam int RW = NP + 1;

  logic [NP-1:0] en_q;
  logic          wr_now;
  logic [PCW_MAXW-1:0] rd_full;

  assign wr_now = acc_i & wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_now) en_q <= wdata_i;
  end

  assign rd_full = pcw_read_val(PCW_MAXW'(en_q));
  assign rdata_o = rd_full[RW-1:0];
  assign en_o    = en_q;

  // R2
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> rdata_o == {1'b0, $past(wdata_i)});
endmodule

// File: rtl/pcw_detect.sv
module pcw_detect
  import pcw_pkg::*;
#(
  parameter int NP = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] lvl_i,
  input  logic [NP-1:0] en_i,
  input  logic          cfg_wr_i,
  input  logic          cfg_arm_i,
  input  logic          clr_i,
  output logic          irq_o
);
  logic [NP-1:0] snap_q;
  logic          armed_q, irq_q;
  logic          arm_req, disarm_req, clr_req, hit_now;

  assign arm_req    = cfg_wr_i & cfg_arm_i;
  assign disarm_req = cfg_wr_i & ~cfg_arm_i;
  assign clr_req    = clr_i;
  assign hit_now    = armed_q &
                      pcw_any_diff(PCW_MAXW'(lvl_i), PCW_MAXW'(snap_q), PCW_MAXW'(en_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (arm_req) begin
      snap_q  <= lvl_i;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (clr_req) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (disarm_req || hit_now) armed_q <= 1'b0;
      if (hit_now) irq_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  // R3
  arm_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_req |=> armed_q && !irq_q && snap_q == $past(lvl_i));
  // R7
  access_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !arm_req) |=> !irq_q && !armed_q);
  // R4
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm_req && !clr_req) |=> !armed_q);
  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(arm_req || clr_req));
  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(hit_now));
endmodule

// File: rtl/port_change_watch.sv
module port_change_watch #(
  parameter int NPORTS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] port_lvl_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_arm_i,
  input  logic              mask_acc_i,
  input  logic              mask_wr_i,
  input  logic [NPORTS-1:0] mask_wdata_i,
  output logic [NPORTS:0]   mask_rdata_o,
  output logic              irq_o
);
  logic [NPORTS-1:0] lvl_sync;
  logic [NPORTS-1:0] en_bits;

  pcw_sync2 #(.W(NPORTS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(port_lvl_i), .q_o(lvl_sync));

  pcw_mask_reg #(.NP(NPORTS)) u_mask (
    .clk(clk), .rst_n(rst_n), .acc_i(mask_acc_i), .wr_i(mask_wr_i),
    .wdata_i(mask_wdata_i), .en_o(en_bits), .rdata_o(mask_rdata_o));

  pcw_detect #(.NP(NPORTS)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_sync), .en_i(en_bits),
    .cfg_wr_i(cfg_wr_i), .cfg_arm_i(cfg_arm_i), .clr_i(mask_acc_i),
    .irq_o(irq_o));
endmodule

// File: tb/port_change_watch_test.sv
module port_change_watch_test;
  localparam int NP = 7;
  localparam logic [2:0] OP_NONE = 3'd0, OP_ARM = 3'd1, OP_DIS = 3'd2,
                         OP_MW = 3'd3, OP_MR = 3'd4;

  typedef struct packed {
    logic [6:0] ports;
    logic [2:0] op;
    logic [6:0] wdata;
    logic       irq;
    logic [7:0] rd;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{7'h00, OP_MW,   7'h7F, 1'b0, 8'h7F}, // R2 enable all
    '{7'h00, OP_ARM,  7'h00, 1'b0, 8'h7F}, // R3 arm, ref 00
    '{7'h01, OP_NONE, 7'h00, 1'b1, 8'h7F}, // R5 change
    '{7'h00, OP_NONE, 7'h00, 1'b1, 8'h7F}, // R6 back to ref, still high
    '{7'h00, OP_MR,   7'h00, 1'b0, 8'h7F}, // R7 read clears
    '{7'h05, OP_NONE, 7'h00, 1'b0, 8'h7F}, // R7 disarmed
    '{7'h05, OP_ARM,  7'h00, 1'b0, 8'h7F}, // R3 ref 05
    '{7'h05, OP_MW,   7'h02, 1'b0, 8'h02}, // R2 only bit1
    '{7'h05, OP_ARM,  7'h00, 1'b0, 8'h02}, // R3
    '{7'h04, OP_NONE, 7'h00, 1'b0, 8'h02}, // R8 masked bit0
    '{7'h06, OP_NONE, 7'h00, 1'b1, 8'h02}, // R5 bit1 moves
    '{7'h06, OP_ARM,  7'h00, 1'b0, 8'h02}, // R3 arm forces low
    '{7'h06, OP_DIS,  7'h00, 1'b0, 8'h02}, // R4 disarm
    '{7'h04, OP_NONE, 7'h00, 1'b0, 8'h02}, // R4 no irq
    '{7'h04, OP_ARM,  7'h00, 1'b0, 8'h02}, // R3
    '{7'h06, OP_NONE, 7'h00, 1'b1, 8'h02}, // R5
    '{7'h06, OP_MW,   7'h7F, 1'b0, 8'h7F}, // R7 write clears
    '{7'h06, OP_ARM,  7'h00, 1'b0, 8'h7F}, // R3
    '{7'h06, OP_ARM,  7'h00, 1'b0, 8'h7F}, // R3 re-arm while armed
    '{7'h07, OP_NONE, 7'h00, 1'b1, 8'h7F}  // R5
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] port_lvl = '0, mask_wdata = '0;
  logic cfg_wr = 1'b0, cfg_arm = 1'b0, mask_acc = 1'b0, mask_wr = 1'b0;
  logic [NP:0] mask_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  port_change_watch #(.NPORTS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .port_lvl_i(port_lvl), .cfg_wr_i(cfg_wr),
    .cfg_arm_i(cfg_arm), .mask_acc_i(mask_acc), .mask_wr_i(mask_wr),
    .mask_wdata_i(mask_wdata), .mask_rdata_o(mask_rdata), .irq_o(irq));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_op(input logic [2:0] op, input logic [6:0] wd);
    cfg_wr   = (op == OP_ARM) || (op == OP_DIS);
    cfg_arm  = (op == OP_ARM);
    mask_acc = (op == OP_MW) || (op == OP_MR);
    mask_wr  = (op == OP_MW);
    mask_wdata = wd;
  endtask

  task automatic clr_op();
    cfg_wr = 1'b0; cfg_arm = 1'b0; mask_acc = 1'b0; mask_wr = 1'b0;
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    check("R1 mask after reset", mask_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      port_lvl = VEC[i].ports;
      set_op(VEC[i].op, VEC[i].wdata);
      @(negedge clk);
      clr_op();
      repeat (3) @(negedge clk);
      check($sformatf("vector %0d irq", i), {7'd0, irq}, {7'd0, VEC[i].irq});
      check($sformatf("vector %0d R2 rdata", i), mask_rdata, VEC[i].rd);
    end

    // R5: one-clock pulse on port 4 while armed (ports 07, ref 06 hit already; re-arm)
    set_op(OP_ARM, 7'h00);
    @(negedge clk); clr_op();
    repeat (3) @(negedge clk);
    check("R3 rearm clears", {7'd0, irq}, 8'h00);
    port_lvl = 7'h17;
    @(negedge clk);
    port_lvl = 7'h07;
    repeat (4) @(negedge clk);
    check("R5 one-clock pulse caught", {7'd0, irq}, 8'h01);

    // R9: change and enable-register read in the same cycle
    set_op(OP_ARM, 7'h00);
    @(negedge clk); clr_op();
    repeat (3) @(negedge clk);
    port_lvl = 7'h0F;
    repeat (2) @(negedge clk);
    set_op(OP_MR, 7'h00);
    @(negedge clk); clr_op();
    check("R9 access beats change", {7'd0, irq}, 8'h00);
    port_lvl = 7'h00;
    repeat (4) @(negedge clk);
    check("R9 left disarmed", {7'd0, irq}, 8'h00);

    // R9: change and arming write in the same cycle
    set_op(OP_ARM, 7'h00);
    @(negedge clk); clr_op();
    repeat (3) @(negedge clk);
    port_lvl = 7'h20;
    repeat (2) @(negedge clk);
    set_op(OP_ARM, 7'h00);
    @(negedge clk); clr_op();
    check("R9 arm beats change", {7'd0, irq}, 8'h00);
    repeat (3) @(negedge clk);
    check("R9 new reference kept", {7'd0, irq}, 8'h00);
    port_lvl = 7'h21;
    repeat (4) @(negedge clk);
    check("R9 still armed after arm", {7'd0, irq}, 8'h01);

    // R9: arming write and enable-register write together
    set_op(OP_ARM, 7'h00);
    mask_acc = 1'b1; mask_wr = 1'b1; mask_wdata = 7'h40;
    @(negedge clk); clr_op();
    repeat (3) @(negedge clk);
    check("R9 arm beats access irq", {7'd0, irq}, 8'h00);
    check("R9 R2 mask stored", mask_rdata, 8'h40);
    port_lvl = 7'h20;
    repeat (4) @(negedge clk);
    check("R8 masked port ignored", {7'd0, irq}, 8'h00);
    port_lvl = 7'h60;
    repeat (4) @(negedge clk);
    check("R9 armed after arm+access", {7'd0, irq}, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule